// File: doc/BRIEF.md
# Floating-Point to Signed Integer Truncating Converter

This unit takes one IEEE-754 operand and turns it into a signed two's-complement integer. Rounding is always toward zero, so any fraction is dropped. A 2-bit format code selects the operand precision: half, single or double. A size bit selects a 32-bit or 64-bit integer result. The converted integer is written into the low bits of a 128-bit destination vector. The bits above the integer either keep the previous destination value or are cleared, as the merge input selects.

The unit is a single registered stage. An operand is presented with `in_valid`, and the result, together with the invalid-operation and inexact flags, appears on the outputs one clock later with `out_valid`. It is meant to sit in a scalar floating-point pipeline, with the register read providing `dst_prev` and the write-back taking `result`.

Top module: `fp_trunc_to_int`

## Requirements
- R1: After reset, `out_valid`, `result`, `flag_invalid` and `flag_inexact` are all zero.
- R2: A result is produced with `out_valid` high exactly one cycle after `in_valid` is high. `out_valid` is low in the cycle after `in_valid` is low.
- R3: The format code selects the operand: 2'b11 is half precision in `src[15:0]`, 2'b00 is single precision in `src[31:0]` and 2'b01 is double precision in `src[63:0]`. Operand bits above the selected width have no effect.
- R4: Format code 2'b10 is rejected. The integer field is zero and `flag_invalid` is set.
- R5: Conversion truncates toward zero. `flag_inexact` is set exactly when a nonzero fraction is discarded from an in-range operand.
- R6: With `size_sel`=0 the result is a 32-bit two's-complement value in `result[31:0]`. With `size_sel`=1 it is a 64-bit value in `result[63:0]`.
- R7: With `merge_en`=1, the bits of `result` above the integer field equal the `dst_prev` bits presented with the operand. With `merge_en`=0, those bits are zero.
- R8: A NaN operand of any format gives integer 0, with `flag_invalid` set and `flag_inexact` clear.
- R9: An operand that is +/-infinity, or whose truncated value lies outside the signed range of the selected width, gives the most positive or most negative value of that width. `flag_invalid` is set and `flag_inexact` is clear.
- R10: An operand equal to -2^(W-1), or a negative operand that truncates to -2^(W-1), converts to that value without `flag_invalid`. Only `flag_inexact` follows R5.
- R11: +0 and -0 give 0 with no flags. Subnormal operands and operands of magnitude below one give 0 with `flag_inexact` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| fmt | input | 2 | Operand format code (11 half, 00 single, 01 double, 10 rejected) |
| size_sel | input | 1 | Integer width: 0 for 32 bits, 1 for 64 bits |
| merge_en | input | 1 | 1 keeps upper destination bits, 0 clears them |
| src | input | 64 | Operand bits, right-aligned |
| dst_prev | input | 128 | Previous destination vector |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Destination vector holding the integer in its low bits |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Inexact flag |

## Verification
The hardest cases sit at the exact edge of the signed range. A double just beyond -2^31 by half a unit must give the minimum value with only inexact set. A double one unit beyond it must saturate with invalid set. For these cases the stimulus uses hand-built double encodings that place a single fraction bit just below the integer boundary. Single and double encodings of exactly -2^31 and -2^63 are also used. Large exact values whose integer part needs a left shift of the mantissa are driven through a double with exponent 60, so that the left-shift path is exercised as well as the right-shift path.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int MAX_INT_W  = 64;
    localparam int NARROW_W   = 32;
    localparam int MANT_W     = 53;
    localparam int EXP_W      = 13;
    localparam int N_FMT      = 3;

    typedef struct packed {
        logic                    sign;
        logic                    nan;
        logic                    inf;
        logic signed [EXP_W-1:0] exp;
        logic [MANT_W-1:0]       mant;
    } fp_unp_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [1:0]  fmt,
    input  logic [63:0] src,
    output fp_unp_t     op,
    output logic        fmt_bad
);
    fp_unp_t u_arr [N_FMT];

    for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
        localparam int EW   = (g == 0) ? 5  : (g == 1) ? 8  : 11;
        localparam int FW   = (g == 0) ? 10 : (g == 1) ? 23 : 52;
        localparam int BIAS = (1 << (EW - 1)) - 1;
        logic [EW-1:0]     e_raw;
        logic [FW-1:0]     f_raw;
        logic [MANT_W-1:0] m_tmp;
        always_comb begin
            e_raw = src[FW +: EW];
            f_raw = src[FW-1:0];
            m_tmp = MANT_W'({(e_raw != '0), f_raw});
            u_arr[g].sign = src[EW + FW];
            u_arr[g].nan  = (e_raw == '1) && (f_raw != '0);
            u_arr[g].inf  = (e_raw == '1) && (f_raw == '0);
            u_arr[g].exp  = (e_raw == '0) ? EXP_W'(1 - BIAS) : EXP_W'(int'(e_raw) - BIAS);
            u_arr[g].mant = m_tmp << (52 - FW);
        end
    end

    always_comb begin
        fmt_bad = 1'b0;
        case (fmt)
            2'b11:   op = u_arr[0];
            2'b00:   op = u_arr[1];
            2'b01:   op = u_arr[2];
            default: begin
                op      = u_arr[1];
                fmt_bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/fcvt_trunc.sv
module fcvt_trunc
    import fcvt_pkg::*;
(
    input  fp_unp_t               op,
    input  logic                  fmt_bad,
    input  logic                  wide,
    output logic [MAX_INT_W-1:0]  ival,
    output logic                  inv,
    output logic                  inx
);
    logic [MAX_INT_W-1:0] mag, limit, maxv, minv;
    logic                 lost, big, ovf;
    logic [5:0]           rsh;
    logic [3:0]           lsh;

    always_comb begin
        mag  = '0;
        lost = 1'b0;
        big  = 1'b0;
        rsh  = '0;
        lsh  = '0;
        if (op.exp < 0) begin
            lost = (op.mant != '0);
        end else if (op.exp > 63) begin
            big = 1'b1;
        end else if (op.exp <= 52) begin
            rsh  = 6'(52 - op.exp);
            mag  = MAX_INT_W'(op.mant >> rsh);
            lost = (op.mant & ((MANT_W'(1) << rsh) - MANT_W'(1))) != '0;
        end else begin
            lsh = 4'(op.exp - 52);
            mag = MAX_INT_W'(op.mant) << lsh;
        end

        limit = wide ? (MAX_INT_W'(1) << (MAX_INT_W - 1)) : (MAX_INT_W'(1) << (NARROW_W - 1));
        maxv  = limit - MAX_INT_W'(1);
        minv  = limit;
        ovf   = big || (op.sign ? (mag > limit) : (mag >= limit));

        ival = '0;
        inv  = 1'b0;
        inx  = 1'b0;
        if (fmt_bad || op.nan) begin
            inv = 1'b1;
        end else if (op.inf || ovf) begin
            inv  = 1'b1;
            ival = op.sign ? minv : maxv;
        end else begin
            ival = op.sign ? (~mag + MAX_INT_W'(1)) : mag;
            inx  = lost;
        end
    end
endmodule

// File: rtl/fp_trunc_to_int.sv
module fp_trunc_to_int
    import fcvt_pkg::*;
#(
    parameter int DST_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       fmt,
    input  logic             size_sel,
    input  logic             merge_en,
    input  logic [63:0]      src,
    input  logic [DST_W-1:0] dst_prev,
    output logic             out_valid,
    output logic [DST_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_inexact
);
    typedef struct packed {
        logic             valid;
        logic [DST_W-1:0] vec;
        logic             inv;
        logic             inx;
    } out_t;

    out_t                 out_d, out_q;
    fp_unp_t              op;
    logic                 fmt_bad;
    logic [MAX_INT_W-1:0] ival;
    logic                 inv, inx;
    logic [DST_W-1:0]     base;

    fcvt_unpack u_unpack (.fmt(fmt), .src(src), .op(op), .fmt_bad(fmt_bad));
    fcvt_trunc  u_trunc  (.op(op), .fmt_bad(fmt_bad), .wide(size_sel),
                          .ival(ival), .inv(inv), .inx(inx));

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        base        = merge_en ? dst_prev : '0;
        if (size_sel) base[MAX_INT_W-1:0] = ival;
        else          base[NARROW_W-1:0]  = ival[NARROW_W-1:0];
        if (in_valid) begin
            out_d.vec = base;
            out_d.inv = inv;
            out_d.inx = inx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid    = out_q.valid;
    assign result       = out_q.vec;
    assign flag_invalid = out_q.inv;
    assign flag_inexact = out_q.inx;

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_zero_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !merge_en |=> result[DST_W-1:MAX_INT_W] == '0);
    p_zero_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !merge_en && !size_sel |=> result[MAX_INT_W-1:NARROW_W] == '0);
    p_keep_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && merge_en && !size_sel |=>
            result[DST_W-1:NARROW_W] == $past(dst_prev[DST_W-1:NARROW_W]));
    p_bad_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fmt == 2'b10 |=> flag_invalid && result[NARROW_W-1:0] == '0);
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(flag_invalid && flag_inexact));
endmodule

// File: tb/tb_fp_trunc_to_int.sv
module tb_fp_trunc_to_int;
    localparam int PERIOD = 10;

    typedef struct {
        logic [127:0] vec;
        logic         inv;
        logic         inx;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   fmt = 2'b00;
    logic         size_sel = 1'b0;
    logic         merge_en = 1'b0;
    logic [63:0]  src = '0;
    logic [127:0] dst_prev = '0;
    logic         out_valid, flag_invalid, flag_inexact;
    logic [127:0] result;

    int   errors = 0;
    int   checks = 0;
    bit   done = 0;
    exp_t sb [$];

    localparam logic [127:0] PAT = 128'hA5A5_5A5A_C3C3_3C3C_0F0F_F0F0_9696_6969;

    fp_trunc_to_int dut (.*);

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [127:0] mk(input logic sz, input logic mg,
                                        input logic [127:0] prev, input logic [63:0] iv);
        logic [127:0] v;
        v = mg ? prev : '0;
        if (sz) v[63:0] = iv;
        else    v[31:0] = iv[31:0];
        return v;
    endfunction

    task automatic send(input string tag, input logic [1:0] f, input logic sz,
                        input logic mg, input logic [63:0] s, input logic [63:0] iv,
                        input logic ei, input logic ex);
        exp_t e;
        e.vec = mk(sz, mg, PAT, iv);
        e.inv = ei;
        e.inx = ex;
        e.tag = tag;
        sb.push_back(e);
        in_valid = 1'b1; fmt = f; size_sel = sz; merge_en = mg; src = s; dst_prev = PAT;
        @(negedge clk);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected result actual=%h expected=none", result);
                end else begin
                    e = sb.pop_front();
                    if (result !== e.vec || flag_invalid !== e.inv || flag_inexact !== e.inx) begin
                        errors++;
                        $display("FAIL %s actual=%h inv=%b inx=%b expected=%h inv=%b inx=%b",
                                 e.tag, result, flag_invalid, flag_inexact, e.vec, e.inv, e.inx);
                    end
                end
            end
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%b/%h/%b/%b expected=0/0/0/0",
                     out_valid, result, flag_invalid, flag_inexact);
        end
        // single precision
        send("R5 1.5",        2'b00, 0, 0, 64'h3FC00000, 64'd1, 0, 1);
        send("R6 -2.75 wide", 2'b00, 1, 1, 64'hC0300000, 64'hFFFFFFFFFFFFFFFE, 0, 1);
        send("R7 100 merge",  2'b00, 0, 1, 64'h42C80000, 64'd100, 0, 0);
        send("R9 2^31 narrow",2'b00, 0, 0, 64'h4F000000, 64'h7FFFFFFF, 1, 0);
        send("R10 -2^31",     2'b00, 0, 1, 64'hCF000000, 64'h80000000, 0, 0);
        send("R6 2^31 wide",  2'b00, 1, 0, 64'h4F000000, 64'h80000000, 0, 0);
        send("R8 NaN single", 2'b00, 1, 0, 64'h7FC00000, 64'd0, 1, 0);
        send("R9 +inf wide",  2'b00, 1, 1, 64'h7F800000, 64'h7FFFFFFFFFFFFFFF, 1, 0);
        send("R9 -inf narrow",2'b00, 0, 0, 64'hFF800000, 64'h80000000, 1, 0);
        send("R11 -0",        2'b00, 1, 0, 64'h80000000, 64'd0, 0, 0);
        send("R11 subnormal", 2'b00, 0, 0, 64'h00000001, 64'd0, 0, 1);
        send("R11 0.75",      2'b00, 0, 1, 64'h3F400000, 64'd0, 0, 1);
        // half precision
        send("R3 half 3.14",  2'b11, 0, 0, 64'h4248, 64'd3, 0, 1);
        send("R3 half -65504",2'b11, 0, 0, 64'hFBFF, 64'hFFFF0020, 0, 0);
        send("R8 NaN half",   2'b11, 1, 1, 64'h7E00, 64'd0, 1, 0);
        send("R3 half upper ignored", 2'b11, 1, 0, 64'hDEADBEEF12343C00, 64'd1, 0, 0);
        // double precision
        send("R5 double pi",  2'b01, 1, 0, 64'h400921FB54442D18, 64'd3, 0, 1);
        send("R10 -2^31-0.5", 2'b01, 0, 1, 64'hC1E0000000100000, 64'h80000000, 0, 1);
        send("R9 -2^31-1",    2'b01, 0, 0, 64'hC1E0000000200000, 64'h80000000, 1, 0);
        send("R9 2^63 wide",  2'b01, 1, 0, 64'h43E0000000000000, 64'h7FFFFFFFFFFFFFFF, 1, 0);
        send("R10 -2^63 wide",2'b01, 1, 1, 64'hC3E0000000000000, 64'h8000000000000000, 0, 0);
        send("R9 huge neg",   2'b01, 0, 0, 64'hFFE0000000000000, 64'h80000000, 1, 0);
        send("R6 2^60+256",   2'b01, 1, 0, 64'h43B0000000000001, 64'h1000000000000100, 0, 0);
        send("R3 single upper ignored", 2'b00, 0, 0, 64'hFFFFFFFF3FC00000, 64'd1, 0, 1);
        // rejected format
        send("R4 bad fmt",    2'b10, 0, 1, 64'h3FC00000, 64'd0, 1, 0);
        send("R4 bad fmt wide", 2'b10, 1, 0, 64'h0, 64'd0, 1, 0);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle out_valid actual=%b expected=0", out_valid);
        end
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 missing results actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule